// File: doc/BRIEF.md
# Ring-Buffer Delay Memory Address Generator

This block sits beside the arithmetic core of an audio effects processor. Each program step may ask for one access to an external delay RAM. The block turns that request into a word address, a read strobe, a write strobe and a format flag. The address is built from four parts: an entry from a 32-slot offset table, the running sample counter, an optional 12-bit address register and an optional +1. In ring mode the sum wraps inside a power-of-two ring length. In table mode the sample counter is left out and the sum wraps at 16 bits. Either way, a page base in units of 4096 words is added after the wrap.

The RAM only accepts accesses on odd steps. A step that asks for a read and a write at once is refused and flagged. Read data comes back the cycle after the read strobe and is held in a register for later steps. In raw format the stored word is padded with eight zero bits. Otherwise the block takes an already unpacked value from an external converter. The block also keeps the address register, which loads either from the shifter output or from the top byte of the input operand.

Top module: `ring_addr_gen`

## Requirements
- R1: After reset the read strobe, write strobe, conflict flag, raw flag and the read-data register are all zero, the address register is zero, every offset entry is zero and the ring length is 0x8000.
- R2: A valid ring-mode step with a request registers, on that clock edge, an address equal to the offset entry selected by `ofs_sel` plus `sample_ctr`, wrapped and rebased as in R6.
- R3: In table mode (`tbl_mode`=1) `sample_ctr` is ignored and the sum wraps at 16 bits instead of at the ring length.
- R4: With `use_areg`=1 the 12-bit address register is added to the sum.
- R5: With `next_word`=1 one is added to the sum.
- R6: In ring mode the sum is ANDed with ring length minus one. The ring length is written through `len_we`. After the wrap, `ring_base` shifted left by 12 is added.
- R7: Read and write strobes are raised only for steps whose `step_idx` bit 0 is 1. Even steps raise no strobe, but the address is still registered.
- R8: A valid step with both `rd_req` and `wr_req` raises `conflict` for one cycle and raises neither strobe.
- R9: `mem_raw` follows `raw_fmt` of the step. `mem_wdata` is `shifted[23:8]` when raw, and `pk_word` otherwise.
- R10: In the cycle after a read strobe, `memval` loads `{rd_word, 8'h00}` if that read was raw, and `unpk_word` otherwise. In every other cycle `memval` holds its value.
- R11: A valid step with `areg_load` loads the address register with `shifted[23:12]` when `shift_mode`=3, and otherwise with `inputs[23:16]` sign-extended to 12 bits. The address of that same step uses the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ofs_we | input | 1 | Offset table write enable |
| ofs_wsel | input | 5 | Offset table write slot |
| ofs_wdata | input | 16 | Offset table write value |
| len_we | input | 1 | Ring length write enable |
| len_wdata | input | 16 | Ring length value (power of two) |
| ring_base | input | 8 | Page base, in 4096-word units |
| step_valid | input | 1 | A program step is presented |
| step_idx | input | 7 | Step number; bit 0 marks odd steps |
| ofs_sel | input | 5 | Offset table slot for this step |
| tbl_mode | input | 1 | Table addressing (no sample counter, 16-bit wrap) |
| use_areg | input | 1 | Add the address register |
| next_word | input | 1 | Add one |
| rd_req | input | 1 | Step requests a read |
| wr_req | input | 1 | Step requests a write |
| raw_fmt | input | 1 | Raw 16-bit format instead of packed |
| sample_ctr | input | 16 | Decrementing sample counter |
| areg_load | input | 1 | Load the address register |
| shift_mode | input | 2 | Shifter mode of the step |
| shifted | input | 24 | Shifter output |
| inputs | input | 24 | Input operand |
| pk_word | input | 16 | Packed form of `shifted` from the external converter |
| unpk_word | input | 24 | Unpacked form of `rd_word` from the external converter |
| rd_word | input | 16 | RAM read data, valid the cycle after `mem_rd` |
| mem_addr | output | 20 | RAM word address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_raw | output | 1 | Format of the current access |
| mem_wdata | output | 16 | RAM write data |
| conflict | output | 1 | Read and write were requested together |
| memval | output | 24 | Last read value |

## Verification
The hardest case to reach is the ordering inside one step: the address must use the old address register while the same step loads a new one. This only shows up when a later step reads the register. The stimulus first loads a known value through the shifter path. It then runs one step that both uses and reloads the register, and a following table-mode step whose sum crosses 16 bits with the new, sign-extended value. The read-data register is also checked on every cycle, including idle and even steps, so a capture at the wrong moment shows as a changed value.

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
  parameter int OFS_N    = 32,
  parameter int WORD_W   = 16,
  parameter int DATA_W   = 24,
  parameter int CTR_W    = 16,
  parameter int AREG_W   = 12,
  parameter int BASE_W   = 8,
  parameter int PAGE_SH  = 12,
  parameter int STEP_W   = 7,
  parameter int ADDR_W   = 20,
  parameter logic [15:0] RING_RST = 16'h8000,
  localparam int SEL_W   = $clog2(OFS_N),
  localparam int SUM_W   = WORD_W + 2,
  localparam int PAD_W   = DATA_W - WORD_W,
  localparam int TOP_W   = DATA_W - 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ofs_we,
  input  logic [SEL_W-1:0]  ofs_wsel,
  input  logic [WORD_W-1:0] ofs_wdata,
  input  logic              len_we,
  input  logic [WORD_W-1:0] len_wdata,
  input  logic [BASE_W-1:0] ring_base,
  input  logic              step_valid,
  input  logic [STEP_W-1:0] step_idx,
  input  logic [SEL_W-1:0]  ofs_sel,
  input  logic              tbl_mode,
  input  logic              use_areg,
  input  logic              next_word,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              raw_fmt,
  input  logic [CTR_W-1:0]  sample_ctr,
  input  logic              areg_load,
  input  logic [1:0]        shift_mode,
  input  logic [DATA_W-1:0] shifted,
  input  logic [DATA_W-1:0] inputs,
  input  logic [WORD_W-1:0] pk_word,
  input  logic [DATA_W-1:0] unpk_word,
  input  logic [WORD_W-1:0] rd_word,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              mem_raw,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              conflict,
  output logic [DATA_W-1:0] memval
);

  logic [WORD_W-1:0] ofs_tbl [OFS_N];
  logic [WORD_W-1:0] ring_len;
  logic [AREG_W-1:0] areg;
  logic [SUM_W-1:0]  sum;
  logic [WORD_W-1:0] wrapped;
  logic [ADDR_W-1:0] next_addr;
  logic              odd, clash, any_req;
  logic [AREG_W-1:0] areg_next;

  assign odd     = step_idx[0];
  assign clash   = rd_req & wr_req;
  assign any_req = rd_req | wr_req;

  assign sum = SUM_W'(ofs_tbl[ofs_sel])
             + (tbl_mode ? SUM_W'(0) : SUM_W'(sample_ctr))
             + (use_areg ? SUM_W'(areg) : SUM_W'(0))
             + SUM_W'(next_word);

  assign wrapped   = tbl_mode ? sum[WORD_W-1:0]
                              : (sum[WORD_W-1:0] & (ring_len - WORD_W'(1)));
  assign next_addr = ADDR_W'(wrapped) + (ADDR_W'(ring_base) << PAGE_SH);

  assign areg_next = (shift_mode == 2'd3)
                   ? shifted[DATA_W-1 -: AREG_W]
                   : {{(AREG_W-TOP_W){inputs[DATA_W-1]}}, inputs[DATA_W-1 -: TOP_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OFS_N; i++) ofs_tbl[i] <= '0;
      ring_len  <= RING_RST[WORD_W-1:0];
      areg      <= '0;
      mem_addr  <= '0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_raw   <= 1'b0;
      mem_wdata <= '0;
      conflict  <= 1'b0;
      memval    <= '0;
    end else begin
      if (ofs_we) ofs_tbl[ofs_wsel] <= ofs_wdata;
      if (len_we) ring_len <= len_wdata;
      mem_rd   <= step_valid & rd_req & ~wr_req & odd;
      mem_wr   <= step_valid & wr_req & ~rd_req & odd;
      conflict <= step_valid & clash;
      if (step_valid & any_req) begin
        mem_addr  <= next_addr;
        mem_raw   <= raw_fmt;
        mem_wdata <= raw_fmt ? shifted[DATA_W-1 -: WORD_W] : pk_word;
      end
      if (step_valid & areg_load) areg <= areg_next;
      if (mem_rd) memval <= mem_raw ? {rd_word, PAD_W'(0)} : unpk_word;
    end
  end

endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk #(
  parameter int STEP_W = 7,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_valid,
  input logic [STEP_W-1:0] step_idx,
  input logic              rd_req,
  input logic              wr_req,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              conflict,
  input logic [DATA_W-1:0] memval
);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R7
  odd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && $past(rst_n)) |-> $past(step_valid && step_idx[0]));

  // R8
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(step_valid && rd_req && wr_req)) |-> (conflict && !mem_rd && !mem_wr));

  // R10
  memval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> $stable(memval));

endmodule

bind ring_addr_gen ring_addr_gen_chk #(.STEP_W(STEP_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_idx(step_idx),
  .rd_req(rd_req), .wr_req(wr_req), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .conflict(conflict), .memval(memval)
);

// File: tb/sim_ring_addr_gen.sv
`timescale 1ns/1ps
module sim_ring_addr_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    logic        ofs_we; logic [4:0] ofs_wsel; logic [15:0] ofs_wdata;
    logic        len_we; logic [15:0] len_wdata; logic [7:0] ring_base;
    logic        step_valid; logic [6:0] step_idx; logic [4:0] ofs_sel;
    logic        tbl_mode, use_areg, next_word, rd_req, wr_req, raw_fmt;
    logic [15:0] sample_ctr; logic areg_load; logic [1:0] shift_mode;
    logic [23:0] shifted, inputs; logic [15:0] pk_word; logic [23:0] unpk_word;
    logic [15:0] rd_word;
  } stim_t;

  typedef struct {
    string tag; bit ca; logic [19:0] addr; bit rd, wr, raw, err; bit cw;
    logic [15:0] wd; logic [23:0] mv;
  } exp_t;

  stim_t s, d;
  exp_t  q[$];
  int checks = 0, fails = 0;

  logic [19:0] mem_addr; logic mem_rd, mem_wr, mem_raw, conflict;
  logic [15:0] mem_wdata; logic [23:0] memval;

  ring_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .ofs_we(d.ofs_we), .ofs_wsel(d.ofs_wsel), .ofs_wdata(d.ofs_wdata),
    .len_we(d.len_we), .len_wdata(d.len_wdata), .ring_base(d.ring_base),
    .step_valid(d.step_valid), .step_idx(d.step_idx), .ofs_sel(d.ofs_sel),
    .tbl_mode(d.tbl_mode), .use_areg(d.use_areg), .next_word(d.next_word),
    .rd_req(d.rd_req), .wr_req(d.wr_req), .raw_fmt(d.raw_fmt), .sample_ctr(d.sample_ctr),
    .areg_load(d.areg_load), .shift_mode(d.shift_mode), .shifted(d.shifted), .inputs(d.inputs),
    .pk_word(d.pk_word), .unpk_word(d.unpk_word), .rd_word(d.rd_word),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_raw(mem_raw),
    .mem_wdata(mem_wdata), .conflict(conflict), .memval(memval)
  );

  task automatic chk(string tag, string f, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, f, act, exp);
    end
  endtask

  task automatic clr();
    s = '{default: '0};
  endtask

  task automatic go(string tag, bit ca, logic [19:0] addr, bit rd, bit wr, bit raw,
                    bit err, bit cw, logic [15:0] wd, logic [23:0] mv);
    exp_t e;
    @(negedge clk);
    d = s;
    e.tag = tag; e.ca = ca; e.addr = addr; e.rd = rd; e.wr = wr; e.raw = raw;
    e.err = err; e.cw = cw; e.wd = wd; e.mv = mv;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      if (e.ca) begin
        chk(e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
        chk(e.tag, "mem_raw", 32'(mem_raw), 32'(e.raw));
      end
      chk(e.tag, "mem_rd", 32'(mem_rd), 32'(e.rd));
      chk(e.tag, "mem_wr", 32'(mem_wr), 32'(e.wr));
      chk(e.tag, "conflict", 32'(conflict), 32'(e.err));
      if (e.cw) chk(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.wd));
      chk(e.tag, "memval", 32'(memval), 32'(e.mv));
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr(); d = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset", "mem_rd", 32'(mem_rd), 0);
    chk("R1 reset", "mem_wr", 32'(mem_wr), 0);
    chk("R1 reset", "conflict", 32'(conflict), 0);
    chk("R1 reset", "mem_raw", 32'(mem_raw), 0);
    chk("R1 reset", "memval", 32'(memval), 0);

    clr(); s.ofs_we = 1; s.ofs_wsel = 0;  s.ofs_wdata = 16'h0010; go("cfg", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    clr(); s.ofs_we = 1; s.ofs_wsel = 1;  s.ofs_wdata = 16'h7FFE; go("cfg", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    clr(); s.ofs_we = 1; s.ofs_wsel = 5;  s.ofs_wdata = 16'h1234; go("cfg", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    clr(); s.ofs_we = 1; s.ofs_wsel = 31; s.ofs_wdata = 16'hFFF0; go("cfg", 0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2 ring-mode read: 0x10 + 5
    clr(); s.step_valid = 1; s.step_idx = 1; s.ofs_sel = 0; s.rd_req = 1; s.sample_ctr = 16'h0005;
    go("R2 ring sum", 1, 20'h00015, 1, 0, 0, 0, 0, 0, 0);
    // R6 / R1 wrap at reset length 0x8000, base 3; R10 float capture of previous read
    clr(); s.step_valid = 1; s.step_idx = 3; s.ofs_sel = 1; s.rd_req = 1; s.raw_fmt = 1;
    s.sample_ctr = 16'h0003; s.ring_base = 8'h03; s.unpk_word = 24'h123456;
    go("R6 R1 wrap+base, R10 float", 1, 20'h03001, 1, 0, 1, 0, 0, 0, 24'h123456);
    // R3 R5 table mode, R9 raw write, R10 raw capture
    clr(); s.step_valid = 1; s.step_idx = 5; s.ofs_sel = 31; s.tbl_mode = 1; s.next_word = 1;
    s.wr_req = 1; s.raw_fmt = 1; s.sample_ctr = 16'h4444; s.shifted = 24'hA5B6C7; s.rd_word = 16'hBEEF;
    go("R3 R5 table, R9 raw wr, R10 raw", 1, 20'h0FFF1, 0, 1, 1, 0, 1, 16'hA5B6, 24'hBEEF00);
    // R11 load from shifter (mode 3)
    clr(); s.step_valid = 1; s.step_idx = 7; s.areg_load = 1; s.shift_mode = 3; s.shifted = 24'hABC123;
    s.rd_word = 16'h9999;
    go("R11 load shifter, R10 hold", 0, 0, 0, 0, 0, 0, 0, 0, 24'hBEEF00);
    // R4 + R11 same-step ordering: uses 0xABC, loads 0xF80
    clr(); s.step_valid = 1; s.step_idx = 9; s.ofs_sel = 0; s.use_areg = 1; s.rd_req = 1;
    s.areg_load = 1; s.shift_mode = 0; s.inputs = 24'h801234;
    go("R4 R11 old areg used", 1, 20'h00ACC, 1, 0, 0, 0, 0, 0, 24'hBEEF00);
    // R3 R4 table wrap with sign-extended register
    clr(); s.step_valid = 1; s.step_idx = 11; s.ofs_sel = 31; s.tbl_mode = 1; s.use_areg = 1;
    s.rd_req = 1; s.unpk_word = 24'h7F0001;
    go("R3 R4 R11 table wrap signext", 1, 20'h00F70, 1, 0, 0, 0, 0, 0, 24'h7F0001);
    // R6 ring length change
    clr(); s.len_we = 1; s.len_wdata = 16'h0100; s.unpk_word = 24'h000042;
    go("R6 len write, R10", 0, 0, 0, 0, 0, 0, 0, 0, 24'h000042);
    clr(); s.step_valid = 1; s.step_idx = 13; s.ofs_sel = 5; s.rd_req = 1; s.raw_fmt = 1;
    s.sample_ctr = 16'h0203;
    go("R6 short ring", 1, 20'h00037, 1, 0, 1, 0, 0, 0, 24'h000042);
    // R7 even steps
    clr(); s.step_valid = 1; s.step_idx = 14; s.ofs_sel = 0; s.rd_req = 1; s.rd_word = 16'h1111;
    go("R7 even read", 1, 20'h00010, 0, 0, 0, 0, 0, 0, 24'h111100);
    clr(); s.step_valid = 1; s.step_idx = 16; s.ofs_sel = 0; s.wr_req = 1; s.rd_word = 16'h2222;
    go("R7 even write, R10 hold", 1, 20'h00010, 0, 0, 0, 0, 0, 0, 24'h111100);
    // R8 clash
    clr(); s.step_valid = 1; s.step_idx = 17; s.rd_req = 1; s.wr_req = 1;
    go("R8 clash", 0, 0, 0, 0, 0, 1, 0, 0, 24'h111100);
    // R9 packed write
    clr(); s.step_valid = 1; s.step_idx = 19; s.ofs_sel = 0; s.wr_req = 1; s.pk_word = 16'h5A5A;
    s.shifted = 24'hFFFFFF;
    go("R9 packed wr", 1, 20'h00010, 0, 1, 0, 0, 1, 16'h5A5A, 24'h111100);
    // R10 idle with changing read data
    clr(); s.rd_word = 16'h3333; s.unpk_word = 24'h444444;
    go("R10 idle hold", 0, 0, 0, 0, 0, 0, 0, 0, 24'h111100);
    clr(); go("idle", 0, 0, 0, 0, 0, 0, 0, 0, 24'h111100);

    repeat (3) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule